// File: doc/BRIEF.md
# Reset Source Capture and System Options

This block merges every reset request on the chip into one synchronous system reset. The requests are power-on detect, an active-low external pin, watchdog timeout, illegal-opcode and illegal-address strobes, an executed stop instruction, and a low-voltage trip. The block stretches the reset so that it is held for a fixed number of cycles after the last request. A status byte records the cause or causes of the most recent reset. Software reads it to learn why the chip restarted.

The block also holds a system options byte that can be written only once after each reset. Some of its bits gate reset sources. The watchdog-enable bit gates watchdog timeouts. The stop-enable bit decides whether a stop instruction is an illegal opcode. The background-pin-enable bit takes its reset value from a mode strap and a security strap. The reset-pin-enable bit survives every reset except power-on. Both bytes are reached through a small register port with a one-bit select, a write strobe and an 8-bit data path.

Top module: `reset_cause_ctrl`

## Requirements
- R1: The status byte reads through `reg_sel_i`=0 with flags at bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low voltage; bits 2 and 0 always read 0.
- R2: While `por_i` is high, `sys_rst_o` is asserted, the status byte becomes 0x82 (power-on and low-voltage flags) and the write-once lock is cleared.
- R3: The external pin is synchronised through two flops; once a low level has passed through, it raises a reset and sets status bit 6.
- R4: A watchdog timeout raises a reset and sets bit 5 only while option bit 7 (watchdog enable) is 1; otherwise it is ignored.
- R5: A low-voltage trip raises a reset and sets bit 1 only while `lvd_rst_en_i` is high.
- R6: An illegal-opcode strobe, or a stop strobe while option bit 5 (stop enable) is 0, raises a reset with bit 4 set; an illegal-address strobe raises a reset with bit 3 set; a stop strobe with stop enable 1 is ignored.
- R7: When a reset begins, all earlier flags are cleared; every source active in that cycle, or later in the same reset, is flagged.
- R8: The options byte (`reg_sel_i`=1) takes only the first write after a reset has ended; later writes, and writes while `sys_rst_o` is high, are ignored; it can be read at any time.
- R9: Option layout: bit 7 watchdog enable (reset 1), bit 6 watchdog period (reset 1), bit 5 stop enable (reset 0), bit 1 background pin enable, bit 0 reset pin enable; bits 4 to 2 read 0.
- R10: On reset, option bit 1 becomes 1 when `mode_strap_i` is low, and otherwise becomes the inverse of `secure_i`.
- R11: Option bit 0 clears to 0 only on power-on and keeps its value through every other reset.
- R12: `sys_rst_o` rises the cycle after a source is first sampled and falls exactly 8 cycles after the last clock edge at which a source was sampled.
- R13: Writes with `reg_sel_i`=0 leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on detect, active high, synchronous master reset |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdog_tmo_i | input | 1 | Watchdog timeout strobe |
| ill_op_i | input | 1 | Illegal-opcode strobe |
| stop_exec_i | input | 1 | Stop instruction executed strobe |
| ill_addr_i | input | 1 | Illegal-address strobe |
| lvd_trip_i | input | 1 | Low-voltage trip level |
| lvd_rst_en_i | input | 1 | Allows a low-voltage trip to reset |
| mode_strap_i | input | 1 | Mode strap: 1 normal, 0 debug |
| secure_i | input | 1 | Security engaged strap |
| reg_sel_i | input | 1 | Register select: 0 status, 1 options |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the selected register |
| sys_rst_o | output | 1 | Stretched synchronous system reset |

## Verification
The hardest case to reach is a gated source that arrives after the write-once window has already been used. To get a watchdog-enable or stop-enable value other than the default, the bench needs a reset to reopen the window, then a first write, and only then the gated strobe. The bench builds that chain from the ports. It also checks that the reset-pin-enable bit survives the intervening resets. It then checks that the gated strobes leave both the reset output and the old status byte alone.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    localparam int unsigned REG_W = 8;

    localparam int unsigned ST_POR  = 7;
    localparam int unsigned ST_PIN  = 6;
    localparam int unsigned ST_WDOG = 5;
    localparam int unsigned ST_IOP  = 4;
    localparam int unsigned ST_IAD  = 3;
    localparam int unsigned ST_LVD  = 1;

    typedef struct packed {
        logic pin;
        logic wdog;
        logic iop;
        logic iad;
        logic lvd;
    } cause_t;

    typedef struct packed {
        logic       wd_en;
        logic       wd_long;
        logic       stop_en;
        logic [2:0] rsvd;
        logic       bkgd_en;
        logic       rpin_en;
    } opts_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_OPTS   = 1'b1
    } reg_sel_e;

    function automatic logic [REG_W-1:0] cause_to_byte(input cause_t c, input logic por);
        logic [REG_W-1:0] b;
        b          = '0;
        b[ST_POR]  = por;
        b[ST_PIN]  = c.pin;
        b[ST_WDOG] = c.wdog;
        b[ST_IOP]  = c.iop;
        b[ST_IAD]  = c.iad;
        b[ST_LVD]  = c.lvd | por;
        return b;
    endfunction

    function automatic logic bkgd_default(input logic mode_normal, input logic secure);
        return mode_normal ? ~secure : 1'b1;
    endfunction

    function automatic opts_t opts_on_reset(input logic bkgd, input logic rpin);
        opts_t o;
        o.wd_en   = 1'b1;
        o.wd_long = 1'b1;
        o.stop_en = 1'b0;
        o.rsvd    = 3'b000;
        o.bkgd_en = bkgd;
        o.rpin_en = rpin;
        return o;
    endfunction

endpackage

// File: rtl/rcu_pin_sync.sv
module rcu_pin_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= INIT;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= INIT;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcu_cause_detect.sv
module rcu_cause_detect
    import rcu_pkg::*;
(
    input  logic   pin_low_i,
    input  logic   wdog_tmo_i,
    input  logic   ill_op_i,
    input  logic   stop_exec_i,
    input  logic   ill_addr_i,
    input  logic   lvd_trip_i,
    input  logic   lvd_rst_en_i,
    input  opts_t  opts_i,
    output cause_t cause_o,
    output logic   any_o
);
    always_comb begin
        cause_o.pin  = pin_low_i;
        cause_o.wdog = wdog_tmo_i & opts_i.wd_en;
        cause_o.iop  = ill_op_i | (stop_exec_i & ~opts_i.stop_en);
        cause_o.iad  = ill_addr_i;
        cause_o.lvd  = lvd_trip_i & lvd_rst_en_i;
        any_o        = |cause_o;
    end
endmodule

// File: rtl/rcu_rst_stretch.sv
module rcu_rst_stretch #(
    parameter int unsigned STRETCH = 8
) (
    input  logic clk,
    input  logic trig_i,
    output logic rst_o
);
    localparam int unsigned CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0] LOAD = CW'(STRETCH - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (trig_i) begin
            active_q <= 1'b1;
            cnt_q    <= LOAD;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign rst_o = active_q;
endmodule

// File: rtl/rcu_status_reg.sv
module rcu_status_reg
    import rcu_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             in_rst_i,
    input  cause_t           cause_i,
    input  logic             any_i,
    output logic [REG_W-1:0] status_o
);
    logic [REG_W-1:0] st_q;
    logic [REG_W-1:0] hit;

    assign hit = cause_to_byte(cause_i, 1'b0);

    always_ff @(posedge clk) begin
        if (por_i)          st_q <= cause_to_byte('0, 1'b1);
        else if (any_i) begin
            if (in_rst_i)   st_q <= st_q | hit;
            else            st_q <= hit;
        end
    end

    assign status_o = st_q;
endmodule

// File: rtl/rcu_opt_reg.sv
module rcu_opt_reg
    import rcu_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             in_rst_i,
    input  logic             bkgd_def_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output opts_t            opts_o,
    output logic             lock_o
);
    opts_t opt_q;
    opts_t wr_val;
    logic  lock_q;

    always_comb begin
        wr_val      = opts_t'(wdata_i);
        wr_val.rsvd = 3'b000;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            opt_q  <= opts_on_reset(bkgd_def_i, 1'b0);
            lock_q <= 1'b0;
        end else if (in_rst_i) begin
            opt_q  <= opts_on_reset(bkgd_def_i, opt_q.rpin_en);
            lock_q <= 1'b0;
        end else if (wr_i && !lock_q) begin
            opt_q  <= wr_val;
            lock_q <= 1'b1;
        end
    end

    assign opts_o = opt_q;
    assign lock_o = lock_q;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcu_pkg::*;
#(
    parameter int unsigned STRETCH     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             ext_rst_n_i,
    input  logic             wdog_tmo_i,
    input  logic             ill_op_i,
    input  logic             stop_exec_i,
    input  logic             ill_addr_i,
    input  logic             lvd_trip_i,
    input  logic             lvd_rst_en_i,
    input  logic             mode_strap_i,
    input  logic             secure_i,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             sys_rst_o
);
    logic             pin_sync;
    cause_t           cause;
    logic             src_any;
    logic             trig_any;
    opts_t            opts;
    logic [REG_W-1:0] opt_byte;
    logic [REG_W-1:0] status_q;
    logic             lock_q;
    logic             opt_wr;

    rcu_pin_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk (clk),
        .rst (por_i),
        .d_i (ext_rst_n_i),
        .q_o (pin_sync)
    );

    rcu_cause_detect u_detect (
        .pin_low_i    (~pin_sync),
        .wdog_tmo_i   (wdog_tmo_i),
        .ill_op_i     (ill_op_i),
        .stop_exec_i  (stop_exec_i),
        .ill_addr_i   (ill_addr_i),
        .lvd_trip_i   (lvd_trip_i),
        .lvd_rst_en_i (lvd_rst_en_i),
        .opts_i       (opts),
        .cause_o      (cause),
        .any_o        (src_any)
    );

    assign trig_any = por_i | src_any;

    rcu_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk    (clk),
        .trig_i (trig_any),
        .rst_o  (sys_rst_o)
    );

    rcu_status_reg u_status (
        .clk      (clk),
        .por_i    (por_i),
        .in_rst_i (sys_rst_o),
        .cause_i  (cause),
        .any_i    (src_any),
        .status_o (status_q)
    );

    assign opt_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_OPTS);

    rcu_opt_reg u_opts (
        .clk        (clk),
        .por_i      (por_i),
        .in_rst_i   (sys_rst_o),
        .bkgd_def_i (bkgd_default(mode_strap_i, secure_i)),
        .wr_i       (opt_wr),
        .wdata_i    (reg_wdata_i),
        .opts_o     (opts),
        .lock_o     (lock_q)
    );

    assign opt_byte    = REG_W'(opts);
    assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_OPTS) ? opt_byte : status_q;
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
    parameter int unsigned STRETCH = 8
) (
    input logic       clk,
    input logic       por_i,
    input logic       sys_rst_o,
    input logic       wdog_tmo_i,
    input logic       trig_any,
    input logic       lock_q,
    input logic [7:0] status_q,
    input logic [7:0] opt_byte
);
    localparam int unsigned QW = $clog2(STRETCH + 2);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH + 1);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (trig_any)            quiet_q <= '0;
        else if (quiet_q < QMAX) quiet_q <= quiet_q + 1'b1;
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (por_i)
        (status_q[2] == 1'b0) && (status_q[0] == 1'b0));

    p_por_flags_r2: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_i) |-> (status_q == 8'h82) && sys_rst_o && !lock_q);

    p_wdog_gate_r4: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && !opt_byte[7] && wdog_tmo_i) |=> !$rose(status_q[5]));

    p_new_clear_r7: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && trig_any) |=> (status_q[7] == 1'b0) && sys_rst_o);

    p_write_once_r8: assert property (@(posedge clk) disable iff (por_i)
        (lock_q && !sys_rst_o) |=> $stable(opt_byte));

    p_opt_rsvd_r9: assert property (@(posedge clk) disable iff (por_i)
        opt_byte[4:2] == 3'b000);

    p_stretch_r12: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> (quiet_q == QW'(STRETCH)));
endmodule

bind reset_cause_ctrl rcu_checker #(.STRETCH(STRETCH)) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .sys_rst_o  (sys_rst_o),
    .wdog_tmo_i (wdog_tmo_i),
    .trig_any   (trig_any),
    .lock_q     (lock_q),
    .status_q   (status_q),
    .opt_byte   (opt_byte)
);

// File: tb/tb_reset_cause_ctrl.sv
`timescale 1ns/1ps
module tb_reset_cause_ctrl;
    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       ext_rst_n_i = 1'b1;
    logic       wdog_tmo_i = 1'b0;
    logic       ill_op_i = 1'b0;
    logic       stop_exec_i = 1'b0;
    logic       ill_addr_i = 1'b0;
    logic       lvd_trip_i = 1'b0;
    logic       lvd_rst_en_i = 1'b0;
    logic       mode_strap_i = 1'b1;
    logic       secure_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       sys_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit rst_seen;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reset_cause_ctrl dut (
        .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .wdog_tmo_i(wdog_tmo_i),
        .ill_op_i(ill_op_i), .stop_exec_i(stop_exec_i), .ill_addr_i(ill_addr_i),
        .lvd_trip_i(lvd_trip_i), .lvd_rst_en_i(lvd_rst_en_i), .mode_strap_i(mode_strap_i),
        .secure_i(secure_i), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sys_rst_o(sys_rst_o)
    );

    always @(negedge clk) if (sys_rst_o === 1'b1) rst_seen = 1'b1;

    // {pin, wdog, iop, iad, stop, lvd, lvd_en, exp_rst, exp_status[7:0]}
    localparam logic [15:0] VEC [0:7] = '{
        16'h8140, 16'h4120, 16'h2110, 16'h1108,
        16'h0408, 16'h0910, 16'h0702, 16'h5128
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel_i = sel;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel_i = sel; reg_wr_i = 1'b1; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] s);
        @(negedge clk);
        rst_seen = 1'b0;
        ext_rst_n_i = ~s[6]; wdog_tmo_i = s[5]; ill_op_i = s[4]; ill_addr_i = s[3];
        stop_exec_i = s[2]; lvd_trip_i = s[1]; lvd_rst_en_i = s[0];
        @(negedge clk);
        ext_rst_n_i = 1'b1; wdog_tmo_i = 1'b0; ill_op_i = 1'b0; ill_addr_i = 1'b0;
        stop_exec_i = 1'b0; lvd_trip_i = 1'b0; lvd_rst_en_i = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 reset held during power-on", {7'd0, sys_rst_o}, 8'h01);
        por_i = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_por();
        check("R12 reset released after power-on", {7'd0, sys_rst_o}, 8'h00);
        rd(1'b0, v); check("R2 R1 status after power-on", v, 8'h82);
        rd(1'b1, v); check("R9 R10 R11 options after power-on", v, 8'hC2);

        wr(1'b0, 8'hFF);
        rd(1'b0, v); check("R13 status write ignored", v, 8'h82);

        for (int i = 0; i < 8; i++) begin
            pulse(VEC[i][15:9]);
            check($sformatf("R3-R7 vector %0d reset seen", i), {7'd0, rst_seen}, {7'd0, VEC[i][8]});
            rd(1'b0, v); check($sformatf("R3 R4 R5 R6 R7 vector %0d status", i), v, VEC[i][7:0]);
        end

        begin : stretch_r12
            int hi = 0;
            @(negedge clk);
            ill_addr_i = 1'b1;
            @(negedge clk);
            ill_addr_i = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (sys_rst_o) hi++;
                @(negedge clk);
            end
            check("R12 reset length in cycles", 8'(hi), 8'd8);
        end

        mode_strap_i = 1'b1; secure_i = 1'b1;
        pulse(7'b0001000);
        rd(1'b1, v); check("R10 normal mode secured", v, 8'hC0);
        mode_strap_i = 1'b0; secure_i = 1'b1;
        pulse(7'b0001000);
        rd(1'b1, v); check("R10 debug mode", v, 8'hC2);
        mode_strap_i = 1'b1; secure_i = 1'b0;
        pulse(7'b0001000);

        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R9 reserved bits read zero", v, 8'hE3);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R8 second write ignored", v, 8'hE3);

        pulse(7'b0001000);
        rd(1'b1, v); check("R11 reset pin enable kept", v, 8'hC3);
        wr(1'b1, 8'h21);
        rd(1'b1, v); check("R8 first write after reset", v, 8'h21);

        pulse(7'b0100000);
        check("R4 watchdog gated no reset", {7'd0, rst_seen}, 8'h00);
        rd(1'b0, v); check("R4 status kept", v, 8'h08);
        pulse(7'b0000100);
        check("R6 stop enabled no reset", {7'd0, rst_seen}, 8'h00);
        rd(1'b0, v); check("R6 status kept", v, 8'h08);
        pulse(7'b0000010);
        check("R5 low voltage unenabled no reset", {7'd0, rst_seen}, 8'h00);

        pulse(7'b1000000);
        rd(1'b0, v); check("R3 pin reset status", v, 8'h40);
        rd(1'b1, v); check("R11 options after pin reset", v, 8'hC3);

        @(negedge clk);
        ill_addr_i = 1'b1;
        @(negedge clk);
        ill_addr_i = 1'b0;
        reg_sel_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
        @(negedge clk);
        reg_wr_i = 1'b0;
        repeat (14) @(negedge clk);
        rd(1'b1, v); check("R8 write during reset ignored", v, 8'hC3);
        wr(1'b1, 8'h40);
        rd(1'b1, v); check("R8 write after reset taken", v, 8'h40);

        do_por();
        rd(1'b0, v); check("R2 status after second power-on", v, 8'h82);
        rd(1'b1, v); check("R11 reset pin enable cleared by power-on", v, 8'hC2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule